// File: doc/BRIEF.md
# Convergent Rounding Word Reducer

This stage takes a wide signed sample from a full-precision filter and turns it into a 16-bit signed word. A parameter fixes how many low-order bits are dropped. Those bits count as the fractional part of the value, and the kept part is set to the nearest integer. When the fraction is exactly one half, the result goes to whichever neighbour is even. Midpoints therefore move up as often as they move down, and the reduced stream carries no DC offset.

A mode pin selects plain truncation in place of rounding, so the two can be compared. Truncation floors the value and always errs toward negative infinity. In both modes a result that does not fit in 16 bits saturates to the nearest extreme. Each sample carries a channel tag, which comes out with the sample, unchanged. The stage has one register of latency. A sample is accepted only when its valid flag is high.

Top module: `cvg_round_reducer`

## Requirements
- R1: The output valid flag is high exactly one clock after a cycle with the input valid high, and low one clock after a cycle with the input valid low.
- R2: The channel tag of an accepted sample appears on the output tag in the same cycle as that sample's result, unchanged.
- R3: With rounding selected (mode pin 0), and the input inside the representable range, the output times 2^FRAC_W differs from the input by at most 2^(FRAC_W-1). That is, the result is the nearest integer to input / 2^FRAC_W.
- R4: With rounding selected, an input whose fraction is exactly one half gives the even neighbour. For example 1.5 gives 2, 2.5 gives 2, 3.5 gives 4, -1.5 gives -2 and -2.5 gives -2.
- R5: With truncation selected (mode pin 1), the output is the floor of input / 2^FRAC_W. For example -0.25 gives -1 and 2.75 gives 2.
- R6: A result above 32767 in either mode gives 32767. This includes a rounding increment that carries past the top, such as 32767.5.
- R7: A result below -32768 in either mode gives -32768.
- R8: While reset is held, the output valid, data and tag are all 0.
- R9: A cycle with the input valid low leaves the output data and tag at their previous values, whatever the data, tag and mode inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trunc_sel | input | 1 | 0 = round to nearest with ties to even, 1 = truncate (floor) |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Wide signed input; the low FRAC_W bits are the fraction |
| in_tag | input | TAG_W | Channel tag of the input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | OUT_W | Reduced signed result (16 bits by default) |
| out_tag | output | TAG_W | Channel tag of the output sample |

## Verification
The hardest case to reach from the ports is a tie whose rounding increment carries the kept value past the 16-bit limit. Here the tie rule and saturation act in the same cycle. Only a tie that sits exactly on the odd value 32767, or on the odd value just below -32768, brings both into play. The stimulus builds those inputs directly, by putting the kept field at the limit and the fraction at exactly one half. The stimulus also places even and odd ties next to each other, with one extra set bit below the guard bit, so that the tie test and the below-guard check are told apart.

// File: rtl/cvg_round_pkg.sv
package cvg_round_pkg;
   typedef enum logic {
      MODE_NEAREST_EVEN = 1'b0,
      MODE_FLOOR        = 1'b1
   } cvr_mode_e;
endpackage

// File: rtl/cvg_round_core.sv
// Computes the kept value plus the rounding increment, one bit wider than the kept field.
module cvg_round_core
   import cvg_round_pkg::*;
#(
   parameter int IN_W   = 28,
   parameter int FRAC_W = 8,
   localparam int KEEP_W = IN_W - FRAC_W,
   localparam int SUM_W  = KEEP_W + 1
) (
   input  logic [IN_W-1:0]  din,
   input  cvr_mode_e        mode,
   output logic [SUM_W-1:0] sum
);
   logic [KEEP_W-1:0] kept;
   logic              guard_b;
   logic              below_b;
   logic              bump;

   assign kept    = din[IN_W-1:FRAC_W];
   assign guard_b = din[FRAC_W-1];

   generate
      if (FRAC_W == 1) begin : g_no_below
         assign below_b = 1'b0;
      end else begin : g_below
         assign below_b = |din[FRAC_W-2:0];
      end
   endgenerate

   // Above one half: round up. Exactly one half: round up only if the kept value is odd.
   always_comb begin
      bump = 1'b0;
      if (mode == MODE_NEAREST_EVEN)
         bump = guard_b & (below_b | kept[0]);
   end

   assign sum = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, bump};
endmodule

// File: rtl/cvg_sat_clip.sv
// Clamps a signed value to the signed output range.
module cvg_sat_clip #(
   parameter int SUM_W = 21,
   parameter int OUT_W = 16
) (
   input  logic [SUM_W-1:0] val,
   output logic [OUT_W-1:0] clipped
);
   localparam int EXT_W = SUM_W - OUT_W + 1;
   localparam logic signed [SUM_W-1:0] HI_LIM = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] LO_LIM = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [SUM_W-1:0] sval;
   assign sval = val;

   always_comb begin
      if (sval > HI_LIM)
         clipped = {1'b0, {(OUT_W-1){1'b1}}};
      else if (sval < LO_LIM)
         clipped = {1'b1, {(OUT_W-1){1'b0}}};
      else
         clipped = val[OUT_W-1:0];
   end
endmodule

// File: rtl/cvg_round_reducer.sv
module cvg_round_reducer
   import cvg_round_pkg::*;
#(
   parameter int IN_W   = 28,
   parameter int FRAC_W = 8,
   parameter int OUT_W  = 16,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trunc_sel,
   input  logic              in_valid,
   input  logic [IN_W-1:0]   in_data,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data,
   output logic [TAG_W-1:0]  out_tag
);
   localparam int KEEP_W = IN_W - FRAC_W;
   localparam int SUM_W  = KEEP_W + 1;

   generate
      if (FRAC_W < 1) begin : g_bad_frac
         $error("cvg_round_reducer: FRAC_W must be at least 1");
      end
      if (KEEP_W < OUT_W) begin : g_bad_keep
         $error("cvg_round_reducer: IN_W - FRAC_W must be at least OUT_W");
      end
      if (OUT_W < 2 || TAG_W < 1) begin : g_bad_out
         $error("cvg_round_reducer: OUT_W >= 2 and TAG_W >= 1 required");
      end
   endgenerate

   cvr_mode_e        mode;
   logic [SUM_W-1:0] rsum;
   logic [OUT_W-1:0] clip_w;

   assign mode = cvr_mode_e'(trunc_sel);

   cvg_round_core #(.IN_W(IN_W), .FRAC_W(FRAC_W)) core_i (
      .din  (in_data),
      .mode (mode),
      .sum  (rsum)
   );

   cvg_sat_clip #(.SUM_W(SUM_W), .OUT_W(OUT_W)) clip_i (
      .val     (rsum),
      .clipped (clip_w)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_tag   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= clip_w;
            out_tag  <= in_tag;
         end
      end
   end
endmodule

// File: rtl/cvg_round_reducer_chk.sv
module cvg_round_reducer_chk #(
   parameter int IN_W   = 28,
   parameter int FRAC_W = 8,
   parameter int OUT_W  = 16,
   parameter int TAG_W  = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              trunc_sel,
   input logic              in_valid,
   input logic [IN_W-1:0]   in_data,
   input logic [TAG_W-1:0]  in_tag,
   input logic              out_valid,
   input logic [OUT_W-1:0]  out_data,
   input logic [TAG_W-1:0]  out_tag
);
   localparam int W = IN_W + 2;
   localparam logic signed [W-1:0] HALF  = W'(1) << (FRAC_W - 1);
   localparam logic signed [W-1:0] ONE   = W'(1) << FRAC_W;
   localparam logic signed [W-1:0] MAXS  = ((W'(1) << (OUT_W - 1)) - W'(1)) << FRAC_W;
   localparam logic signed [W-1:0] MINS  = -(W'(1) << (OUT_W - 1 + FRAC_W));
   localparam logic signed [W-1:0] TOPS  = W'(1) << (OUT_W - 1 + FRAC_W);

   logic [IN_W-1:0]  in_q;
   logic             trunc_q;
   logic [TAG_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q    <= '0;
         trunc_q <= 1'b0;
         tag_q   <= '0;
      end else if (in_valid) begin
         in_q    <= in_data;
         trunc_q <= trunc_sel;
         tag_q   <= in_tag;
      end
   end

   logic signed [W-1:0] in_x;
   logic signed [W-1:0] scaled;
   logic signed [W-1:0] diff;
   logic                in_rng;
   logic                is_tie;

   assign in_x   = {{2{in_q[IN_W-1]}}, in_q};
   assign scaled = {{(W-OUT_W-FRAC_W){out_data[OUT_W-1]}}, out_data, {FRAC_W{1'b0}}};
   assign diff   = in_x - scaled;
   assign in_rng = (in_x >= MINS) && (in_x <= MAXS);
   assign is_tie = (in_q[FRAC_W-1:0] == HALF[FRAC_W-1:0]);

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   p_tag_carried_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_tag == tag_q));
   p_nearest_r3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !trunc_q && in_rng) |-> ((diff <= HALF) && (diff >= -HALF)));
   p_tie_even_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !trunc_q && is_tie && (in_x >= MINS) && (in_x < MAXS)) |-> !out_data[0]);
   p_floor_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && trunc_q && in_rng) |-> ((diff >= 0) && (diff < ONE)));
   p_sat_high_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (in_x >= TOPS)) |-> (out_data == {1'b0, {(OUT_W-1){1'b1}}}));
   p_sat_low_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && (in_x < MINS - HALF)) |-> (out_data == {1'b1, {(OUT_W-1){1'b0}}}));
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (!out_valid && (out_data == '0) && (out_tag == '0)));
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_data) && $stable(out_tag)));
endmodule

bind cvg_round_reducer cvg_round_reducer_chk #(
   .IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .TAG_W(TAG_W)
) chk_i (.*);

// File: tb/cvg_round_reducer_tb_top.sv
`timescale 1ns/1ps
module cvg_round_reducer_tb_top;
   localparam int IN_W = 28, FRAC_W = 8, OUT_W = 16, TAG_W = 3;
   localparam int NV = 20;

   // value = integer * 256 + fraction/256 (FRAC_W = 8)
   localparam bit VMODE [NV] = '{0,0,0,0,0, 0,0,0,0,1, 1,1,0,0,0, 0,0,0,1,1};
   localparam int VIN [NV] = '{
      384, 640, 896, -384, -640,
      576, 704, 641, -64, -64,
      704, 896, 8388480, 8388224, 10240000,
      -10240000, -8388736, -8388800, 10240128, -8388736};
   localparam int VEXP [NV] = '{
      2, 2, 4, -2, -2,
      2, 3, 3, 0, -1,
      2, 3, 32767, 32766, 32767,
      -32768, -32768, -32768, 32767, -32768};
   localparam string VREQ [NV] = '{
      "R4", "R4", "R4", "R4", "R4",
      "R3", "R3", "R3", "R3", "R5",
      "R5", "R5", "R6", "R4", "R6",
      "R7", "R4", "R7", "R6", "R7"};

   logic              clk = 1'b0;
   logic              rst;
   logic              trunc_sel;
   logic              in_valid;
   logic [IN_W-1:0]   in_data;
   logic [TAG_W-1:0]  in_tag;
   logic              out_valid;
   logic [OUT_W-1:0]  out_data;
   logic [TAG_W-1:0]  out_tag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cvg_round_reducer #(.IN_W(IN_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W), .TAG_W(TAG_W)) dut_i (
      .clk, .rst, .trunc_sel, .in_valid, .in_data, .in_tag,
      .out_valid, .out_data, .out_tag
   );

   task automatic check(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input bit mode, input int val, input int tg);
      @(negedge clk);
      trunc_sel = mode;
      in_valid  = 1'b1;
      in_data   = IN_W'(val);
      in_tag    = TAG_W'(tg);
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   initial begin
      rst = 1'b1; trunc_sel = 1'b0; in_valid = 1'b0; in_data = '0; in_tag = '0;
      repeat (3) @(negedge clk);
      // R8: outputs clear under reset, even with a valid sample presented
      in_valid = 1'b1; in_data = IN_W'(5000); in_tag = 3'd5;
      @(negedge clk);
      check("R8", int'(out_valid), 0, "valid in reset");
      check("R8", int'($signed(out_data)), 0, "data in reset");
      check("R8", int'(out_tag), 0, "tag in reset");
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      check("R1", int'(out_valid), 0, "valid after idle");

      for (int i = 0; i < NV; i++) begin
         apply(VMODE[i], VIN[i], i % 8);
         check("R1", int'(out_valid), 1, "valid one cycle later");
         check(VREQ[i], int'($signed(out_data)), VEXP[i], $sformatf("vector %0d data", i));
         check("R2", int'(out_tag), i % 8, $sformatf("vector %0d tag", i));
      end

      // R9: idle cycles with changed data, tag and mode leave the outputs untouched
      apply(1'b0, 2816, 6);           // 11.0 -> 11
      check("R3", int'($signed(out_data)), 11, "11.0");
      trunc_sel = 1'b1; in_data = IN_W'(-10240000); in_tag = 3'd1;
      @(negedge clk);
      check("R1", int'(out_valid), 0, "valid low when idle");
      @(negedge clk);
      check("R9", int'($signed(out_data)), 11, "data held while idle");
      check("R9", int'(out_tag), 6, "tag held while idle");

      // Back-to-back samples: adjacent odd/even ties
      @(negedge clk);
      trunc_sel = 1'b0; in_valid = 1'b1; in_data = IN_W'(-896); in_tag = 3'd2;   // -3.5 -> -4
      @(negedge clk);
      check("R4", int'($signed(out_data)), -4, "-3.5");
      check("R2", int'(out_tag), 2, "tag back-to-back a");
      in_data = IN_W'(-1152); in_tag = 3'd4;                                    // -4.5 -> -4
      @(negedge clk);
      in_valid = 1'b0;
      check("R4", int'($signed(out_data)), -4, "-4.5");
      check("R2", int'(out_tag), 4, "tag back-to-back b");
      check("R1", int'(out_valid), 1, "valid back-to-back");

      // R8: reset mid-stream clears outputs
      rst = 1'b1;
      @(negedge clk);
      check("R8", int'(out_valid), 0, "valid after late reset");
      check("R8", int'($signed(out_data)), 0, "data after late reset");
      rst = 1'b0;
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog expired");
         end
         wait (done);
      join_any
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule